// File: doc/BRIEF.md
# Programmable Parallel I/O Port

This block sits on a simple processor bus and gives software three 8-bit parallel ports (A, B and C) plus one control register. A two-bit address picks which of the four is read or written. Software sets the direction of each port at run time with a configuration word: Port A and Port B each turn as a whole, and Port C is split into an upper and a lower nibble that turn independently. The same control address also accepts a single-bit command that sets or clears one Port C output bit and leaves the other seven untouched. This lets software toggle one strobe or select line without a read-modify-write.

The bus is sampled on the rising clock edge. An access takes place in every cycle in which the active-low select is low together with the active-low read or write strobe. Reads are combinational, so the data is valid in the same cycle as the strobe. For each port the block has an output latch, a per-bit output enable and a pin input. The surrounding pad logic makes the actual tri-state pins from these. Only plain input/output operation is supported. Any handshake-mode bits in the configuration word are stored but have no effect.

Top module: `pario_port`

## Requirements
- R1: The address selects the target: 0 is Port A, 1 is Port B, 2 is Port C and 3 is the control register.
- R2: While `rst_n` is low at a clock edge, the block returns to its reset state. In that state every port is an input (all `*_oe` low), every output latch is 0, and the control register reads back 8'h9B.
- R3: A byte with bit 7 = 1 written to address 3 is a configuration word and is stored as written. In it, a 1 means input: bit 4 sets all of Port A, bit 1 sets all of Port B, bit 3 sets Port C bits 7:4 and bit 0 sets Port C bits 3:0. The output enables are the inverse of these bits.
- R4: Writing a configuration word clears the output latches of all three ports to 0 in the same cycle.
- R5: A write to a port address stores the byte in that port's latch whatever the direction. Only bits configured as outputs drive their `*_out` value with `*_oe` high.
- R6: A read of a port returns the pin value for bits configured as inputs and the latch value for bits configured as outputs. This is decided bit by bit, so Port C can mix its two nibbles.
- R7: A byte with bit 7 = 0 written to address 3 is a bit command. Bits 3:1 give the Port C bit number and bit 0 gives its new value. No other Port C bit changes, and the stored configuration word does not change.
- R8: When `cs_n` is high, the write strobe changes no state and `rdata` stays 0 even if `rd_n` is low.
- R9: When no read is in progress, `rdata` is 0. A read changes no latch and no configuration.
- R10: The configuration word 8'h92 makes Port A and Port B inputs and all of Port C outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data from the bus |
| rdata | output | 8 | Read data to the bus, 0 when not reading |
| pa_pin | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_pin | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_pin | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
The bench targets the split Port C. It reads with the upper nibble as input and the lower nibble as output, so a design that chose the read source per port and not per bit would return all pin bits or all latch bits. Bit commands go to bits 0 and 5 in turn, so a design that decoded the bit number wrongly, or let the command overwrite the configuration word, would show stray Port C bits or a changed readback. The bench also reads back ports after a new configuration word to catch latches that survive the reconfiguration. It drives write strobes with the chip deselected to catch a decoder that ignores `cs_n`.

// File: rtl/pario_pkg.sv
// Package pario_pkg
// Shared constants for the parallel I/O port: register selects and the
// bit positions of the control byte. Assumes an 8-bit data path.
package pario_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    // control byte layout (a 1 in a direction bit means input)
    localparam int CW_KIND_BIT = 7;  // 1: configuration word, 0: bit command
    localparam int CW_A_IN     = 4;
    localparam int CW_CHI_IN   = 3;
    localparam int CW_B_IN     = 1;
    localparam int CW_CLO_IN   = 0;

    // bit-command layout
    localparam int BC_SEL_LSB  = 1;
    localparam int BC_VAL_BIT  = 0;

    // configuration held after reset: every port an input
    localparam logic [DATA_W-1:0] CW_RESET = 8'h9B;

endpackage

// File: rtl/pario_ctrl.sv
// Module pario_ctrl
// Holds the configuration word and splits control-address writes into
// configuration loads and Port C bit commands. It derives the per-bit
// direction vectors of the three ports.
// Assumes ctrl_wr is already qualified by chip select and address.
module pario_ctrl
    import pario_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic [W-1:0]         wdata,
    output logic [W-1:0]         mode_q,
    output logic                 mode_load,
    output logic                 bit_cmd,
    output logic [$clog2(W)-1:0] bit_sel,
    output logic                 bit_val,
    output logic [W-1:0]         dir_a,
    output logic [W-1:0]         dir_b,
    output logic [W-1:0]         dir_c
);

    localparam int SW   = $clog2(W);
    localparam int HALF = W / 2;

    // Purpose: classify a control-address write by its top bit.
    always_comb begin
        mode_load = ctrl_wr &  wdata[CW_KIND_BIT];
        bit_cmd   = ctrl_wr & ~wdata[CW_KIND_BIT];
        bit_sel   = wdata[BC_SEL_LSB +: SW];
        bit_val   = wdata[BC_VAL_BIT];
    end

    // Purpose: keep the last configuration word written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= CW_RESET;
        else if (mode_load)
            mode_q <= wdata;
    end

    // Purpose: expand the direction bits to one bit per pin (1 = input).
    always_comb begin
        dir_a = {W{mode_q[CW_A_IN]}};
        dir_b = {W{mode_q[CW_B_IN]}};
        dir_c = {{(W-HALF){mode_q[CW_CHI_IN]}}, {HALF{mode_q[CW_CLO_IN]}}};
    end

    // R3
    mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load |=> mode_q == $past(wdata));

    // R7
    bitcmd_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cmd |=> $stable(mode_q));

endmodule

// File: rtl/pario_latch.sv
// Module pario_latch
// Output latch of one port. It clears on a configuration load, takes a
// whole byte on a port write and, if BITSET is set, updates a single bit
// on a bit command.
// Assumes clear, load and bset never come in the same cycle.
module pario_latch #(
    parameter int W      = 8,
    parameter bit BITSET = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 load,
    input  logic [W-1:0]         load_data,
    input  logic                 bset,
    input  logic [$clog2(W)-1:0] bsel,
    input  logic                 bval,
    output logic [W-1:0]         q
);

    localparam int SW = $clog2(W);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (BITSET) begin : g_cmd
            // Purpose: latch bit with whole-byte load and single-bit command.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[i] <= 1'b0;
                else if (clear)
                    q[i] <= 1'b0;
                else if (load)
                    q[i] <= load_data[i];
                else if (bset && (bsel == SW'(i)))
                    q[i] <= bval;
            end
        end else begin : g_plain
            // Purpose: latch bit with whole-byte load only.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[i] <= 1'b0;
                else if (clear)
                    q[i] <= 1'b0;
                else if (load)
                    q[i] <= load_data[i];
            end
        end
    end

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> q == '0);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load && !(BITSET && bset)) |=> $stable(q));

    // R7
    one_bit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (BITSET && bset && !clear && !load) |=>
            $countones(q ^ $past(q)) <= 1);

endmodule

// File: rtl/pario_rdmux.sv
// Module pario_rdmux
// Read path: picks pin or latch bit by bit for each port and selects the
// addressed register. It drives 0 when no read is in progress.
// Assumes dir vectors use 1 = input.
module pario_rdmux
    import pario_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         rd_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] pin_a,
    input  logic [W-1:0] pin_b,
    input  logic [W-1:0] pin_c,
    input  logic [W-1:0] lat_a,
    input  logic [W-1:0] lat_b,
    input  logic [W-1:0] lat_c,
    input  logic [W-1:0] dir_a,
    input  logic [W-1:0] dir_b,
    input  logic [W-1:0] dir_c,
    input  logic [W-1:0] mode_q,
    output logic [W-1:0] rdata
);

    logic [W-1:0] view_a, view_b, view_c;

    // Purpose: per-bit choice between pin and latch.
    always_comb begin
        view_a = (dir_a & pin_a) | (~dir_a & lat_a);
        view_b = (dir_b & pin_b) | (~dir_b & lat_b);
        view_c = (dir_c & pin_c) | (~dir_c & lat_c);
    end

    // Purpose: address-selected read data, gated by the read enable.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (reg_sel_e'(addr))
                SEL_A:    rdata = view_a;
                SEL_B:    rdata = view_b;
                SEL_C:    rdata = view_c;
                SEL_CTRL: rdata = mode_q;
            endcase
        end
    end

endmodule

// File: rtl/pario_port.sv
// Module pario_port
// Top of the programmable parallel I/O port: bus decode, configuration
// register, three output latches and the read multiplexer.
// Assumes bus signals are synchronous to clk; each strobe cycle is one access.
module pario_port
    import pario_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [1:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [7:0]  pa_pin,
    output logic [7:0]  pa_out,
    output logic [7:0]  pa_oe,
    input  logic [7:0]  pb_pin,
    output logic [7:0]  pb_out,
    output logic [7:0]  pb_oe,
    input  logic [7:0]  pc_pin,
    output logic [7:0]  pc_out,
    output logic [7:0]  pc_oe
);

    localparam int W  = DATA_W;
    localparam int SW = $clog2(W);

    logic          wr_act, rd_act;
    logic          wr_a, wr_b, wr_c, wr_ctrl;
    logic [W-1:0]  mode_q, dir_a, dir_b, dir_c;
    logic          mode_load, bit_cmd, bit_val;
    logic [SW-1:0] bit_sel;

    // Purpose: qualify strobes with chip select and decode the address.
    always_comb begin
        wr_act  = ~cs_n & ~wr_n;
        rd_act  = ~cs_n & ~rd_n;
        wr_a    = wr_act && (reg_sel_e'(addr) == SEL_A);
        wr_b    = wr_act && (reg_sel_e'(addr) == SEL_B);
        wr_c    = wr_act && (reg_sel_e'(addr) == SEL_C);
        wr_ctrl = wr_act && (reg_sel_e'(addr) == SEL_CTRL);
    end

    pario_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (wr_ctrl),
        .wdata     (wdata),
        .mode_q    (mode_q),
        .mode_load (mode_load),
        .bit_cmd   (bit_cmd),
        .bit_sel   (bit_sel),
        .bit_val   (bit_val),
        .dir_a     (dir_a),
        .dir_b     (dir_b),
        .dir_c     (dir_c)
    );

    pario_latch #(.W(W), .BITSET(1'b0)) u_lat_a (
        .clk (clk), .rst_n (rst_n), .clear (mode_load), .load (wr_a),
        .load_data (wdata), .bset (1'b0), .bsel ('0), .bval (1'b0), .q (pa_out)
    );

    pario_latch #(.W(W), .BITSET(1'b0)) u_lat_b (
        .clk (clk), .rst_n (rst_n), .clear (mode_load), .load (wr_b),
        .load_data (wdata), .bset (1'b0), .bsel ('0), .bval (1'b0), .q (pb_out)
    );

    pario_latch #(.W(W), .BITSET(1'b1)) u_lat_c (
        .clk (clk), .rst_n (rst_n), .clear (mode_load), .load (wr_c),
        .load_data (wdata), .bset (bit_cmd), .bsel (bit_sel), .bval (bit_val),
        .q (pc_out)
    );

    // Purpose: output enables are the inverse of the input-direction bits.
    always_comb begin
        pa_oe = ~dir_a;
        pb_oe = ~dir_b;
        pc_oe = ~dir_c;
    end

    pario_rdmux #(.W(W)) u_rd (
        .rd_en  (rd_act),
        .addr   (addr),
        .pin_a  (pa_pin),
        .pin_b  (pb_pin),
        .pin_c  (pc_pin),
        .lat_a  (pa_out),
        .lat_b  (pb_out),
        .lat_c  (pc_out),
        .dir_a  (dir_a),
        .dir_b  (dir_b),
        .dir_c  (dir_c),
        .mode_q (mode_q),
        .rdata  (rdata)
    );

    // R8
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(mode_q) && $stable(pa_out) && $stable(pb_out)
                 && $stable(pc_out));

    // R4
    reconfig_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act && reg_sel_e'(addr) == SEL_CTRL && wdata[CW_KIND_BIT]) |=>
            (pa_out == '0) && (pb_out == '0) && (pc_out == '0));

    // R9
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> rdata == '0);

endmodule

// File: tb/sim_pario_port.sv
module sim_pario_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pa_pin = '0, pb_pin = '0, pc_pin = '0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pario_port u0 (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .rd_n (rd_n), .wr_n (wr_n),
        .addr (addr), .wdata (wdata), .rdata (rdata),
        .pa_pin (pa_pin), .pa_out (pa_out), .pa_oe (pa_oe),
        .pb_pin (pb_pin), .pb_out (pb_out), .pb_oe (pb_oe),
        .pc_pin (pc_pin), .pc_out (pc_out), .pc_oe (pc_oe)
    );

    // vector: {req[3:0], op[1:0] (0 write, 1 read), addr, data, pa, pb, pc, expected rdata}
    localparam int NV = 20;
    localparam logic [47:0] VEC [0:NV-1] = '{
        {4'd2,  2'd1, 2'd3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h9B}, // R2 reset config
        {4'd1,  2'd1, 2'd0, 8'h00, 8'h5A, 8'h00, 8'h00, 8'h5A}, // R1 port A pins
        {4'd1,  2'd1, 2'd1, 8'h00, 8'h00, 8'hC3, 8'h00, 8'hC3}, // R1 port B pins
        {4'd1,  2'd1, 2'd2, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h3C}, // R1 port C pins
        {4'd10, 2'd0, 2'd3, 8'h92, 8'h00, 8'h00, 8'h00, 8'h00}, // R10
        {4'd3,  2'd1, 2'd3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h92}, // R3 readback
        {4'd5,  2'd0, 2'd2, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00}, // R5
        {4'd6,  2'd1, 2'd2, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hA5}, // R6 output reads latch
        {4'd6,  2'd1, 2'd0, 8'h00, 8'h11, 8'h00, 8'h00, 8'h11}, // R6 input reads pins
        {4'd4,  2'd0, 2'd3, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00}, // R4 reconfig
        {4'd4,  2'd1, 2'd2, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00}, // R4 latch cleared
        {4'd5,  2'd0, 2'd0, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00}, // R5
        {4'd6,  2'd1, 2'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h77}, // R6
        {4'd5,  2'd0, 2'd1, 8'h66, 8'h00, 8'h00, 8'h00, 8'h00}, // R5
        {4'd6,  2'd1, 2'd1, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h66}, // R6
        {4'd3,  2'd0, 2'd3, 8'h88, 8'h00, 8'h00, 8'h00, 8'h00}, // R3 C hi in, lo out
        {4'd5,  2'd0, 2'd2, 8'h36, 8'h00, 8'h00, 8'h00, 8'h00}, // R5
        {4'd6,  2'd1, 2'd2, 8'h00, 8'h00, 8'h00, 8'hC9, 8'hC6}, // R6 mixed nibbles
        {4'd9,  2'd1, 2'd2, 8'h00, 8'h00, 8'h00, 8'hC9, 8'hC6}, // R9 read repeats
        {4'd3,  2'd1, 2'd3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h88}  // R3
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        #1;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2 reset state at the pins
        chk("R2 pa_oe", pa_oe, 8'h00);
        chk("R2 pb_oe", pb_oe, 8'h00);
        chk("R2 pc_oe", pc_oe, 8'h00);
        chk("R2 pc_out", pc_out, 8'h00);
        chk("R9 idle rdata", rdata, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            v = VEC[i];
            pa_pin = v[31:24]; pb_pin = v[23:16]; pc_pin = v[15:8];
            if (v[43:42] == 2'd0) begin
                bus_wr(v[41:40], v[39:32]);
            end else begin
                bus_rd(v[41:40], r);
                chk($sformatf("R%0d vector %0d", v[47:44], i), r, v[7:0]);
            end
        end

        // R4 and R3: all outputs
        bus_wr(2'd3, 8'h80);
        chk("R3 pa_oe all out", pa_oe, 8'hFF);
        chk("R3 pc_oe all out", pc_oe, 8'hFF);
        chk("R4 pc_out cleared", pc_out, 8'h00);
        chk("R4 pa_out cleared", pa_out, 8'h00);

        // R7 bit commands on Port C
        bus_wr(2'd3, 8'h0B);
        chk("R7 set bit5", pc_out, 8'h20);
        bus_wr(2'd3, 8'h01);
        chk("R7 set bit0", pc_out, 8'h21);
        bus_wr(2'd3, 8'h0A);
        chk("R7 clear bit5", pc_out, 8'h01);
        bus_rd(2'd3, r);
        chk("R7 config unchanged", r, 8'h80);

        // R8 deselected strobes
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd2; wdata = 8'hFF;
        @(negedge clk);
        wr_n = 1'b1; addr = 2'd3; wdata = 8'h9B;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b0; addr = 2'd3;
        #1;
        chk("R8 rdata deselected", rdata, 8'h00);
        rd_n = 1'b1;
        chk("R8 pc_out kept", pc_out, 8'h01);
        chk("R8 pc_oe kept", pc_oe, 8'hFF);

        // R10 and R5: write to an input port
        bus_wr(2'd3, 8'h92);
        chk("R10 pa_oe", pa_oe, 8'h00);
        chk("R10 pb_oe", pb_oe, 8'h00);
        chk("R10 pc_oe", pc_oe, 8'hFF);
        bus_wr(2'd0, 8'h33);
        chk("R5 latch stored on input port", pa_out, 8'h33);
        pa_pin = 8'h44;
        bus_rd(2'd0, r);
        chk("R5 input port reads pins", r, 8'h44);

        // R2 reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2 pc_oe after reset", pc_oe, 8'h00);
        chk("R2 pa_out after reset", pa_out, 8'h00);
        bus_rd(2'd3, r);
        chk("R2 config after reset", r, 8'h9B);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule